// File: doc/BRIEF.md
# Interrupt and Trap Sequencer

This block sits next to a small processor core and decides when control leaves the running program. It watches three kinds of events: level-held interrupt requests from several sources, each with its own 3-bit priority; a software trap carrying an 8-bit number; and hardware faults (a bad memory access, a division by zero, or a privileged operation tried in user mode). When an event is taken, the block saves the core's program counter and status word on a stack in memory, raises the current priority level where that applies, switches to supervisor mode, reads the handler address from a vector table and hands it to the core.

A return request runs the same steps backwards. The saved status word is popped first, which restores the priority level and the mode. The saved program counter is popped next and handed back to the core. All memory traffic goes through one request/acknowledge port. While a sequence runs, `busy` stalls the core, and events are only looked at while the sequencer is idle.

Vector numbers: 0 is a bad memory access, 1 is divide by zero, 2 is a privileged operation, and 3 is unused. Traps use vectors 4 to 259 (4 plus the trap number). Interrupt source i uses vector 260 plus i. The handler address for vector v is the word at `VEC_BASE + v`. Memory is word addressed.

Top module: `evt_seq`

## Requirements
- R1: After reset, `busy`, `mem_req` and `pc_load` are low, `sup_mode` is 1, `cur_ipl` is 0 and `sp_out` equals `SP_INIT`.
- R2: An interrupt request whose level is less than or equal to `cur_ipl` is never taken. It causes no memory access, no change of `sp_out` and no `busy`. A request whose level is strictly above `cur_ipl` is taken.
- R3: Interrupt inputs pass through a two-stage synchronizer. Among the unmasked pending sources, the one with the highest level wins, and the lowest index wins a tie. Taking source i uses vector 260+i and sets `cur_ipl` to that source's level.
- R4: Entry first writes the PC to address SP-1, then writes the status word to SP-2, and leaves `sp_out` at SP-2. In the status word, bit 3 is the mode (1 = supervisor) and bits 2:0 are the level that was current before entry.
- R5: After both pushes, the new level and supervisor mode are in effect. The handler word is then read at `VEC_BASE + vector`. `pc_load` pulses for one cycle with `pc_target` holding that word, and `busy` is low in the next cycle.
- R6: A trap is taken in either mode and uses vector 4 plus the trap number. It leaves `sup_mode` at 1 and `cur_ipl` unchanged.
- R7: A bad memory access uses vector 0 and a divide by zero uses vector 1. If both are raised together, the bad access wins. Neither changes `cur_ipl`.
- R8: `priv_op` in user mode raises the exception on vector 2. In supervisor mode it has no effect.
- R9: Events taken in the same cycle are ranked: exceptions first, then the trap, then interrupts, then a return.
- R10: A return pops the status word from SP, restoring `cur_ipl` and `sup_mode`. It then pops the PC from SP+1 and loads it through `pc_load`. `sp_out` ends at SP+2.
- R11: `busy` is high for the whole of every sequence. A trap, fault or return pulse that arrives while `busy` is high is dropped.
- R12: `mem_req` and `mem_addr` hold steady until `mem_ack`. `sp_out` moves by exactly one word on each acknowledged stack access and stays the same otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NSRC | Level-held interrupt requests, asynchronous |
| irq_lvl | input | NSRC*3 | Priority of each source, source i at bits 3i+2:3i |
| trap_req | input | 1 | Trap request pulse from the core |
| trap_num | input | 8 | Trap number |
| fault_mem | input | 1 | Bad memory access fault |
| fault_div | input | 1 | Divide by zero fault |
| priv_op | input | 1 | Core is issuing a privileged operation |
| ret_req | input | 1 | Return from handler request |
| core_pc | input | AW | PC to save on entry |
| busy | output | 1 | Sequence in progress, core stalls |
| pc_load | output | 1 | One-cycle strobe to load `pc_target` |
| pc_target | output | AW | Handler address or restored PC |
| sup_mode | output | 1 | 1 = supervisor, 0 = user |
| cur_ipl | output | 3 | Current priority level |
| sp_out | output | AW | Stack pointer |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |

## Verification
A corrupted stack pointer shows at the ports at the next stack access: the write address or the read address is off by the same amount, and the error stays until reset. A wrong priority level shows within three cycles of the next interrupt request, as a request that is taken when it should be masked or masked when it should be taken. It also shows in bits 2:0 of the next pushed status word. The bench sweeps every trap number and every source/level/current-level combination, so a wrong mode or level bit reaches a compared port within a single entry/return pair.

// File: rtl/evt_pkg.sv
package evt_pkg;
    localparam int LVL_W    = 3;
    localparam int TRAP_W   = 8;
    localparam int NEXC     = 4;
    localparam int VEC_W    = 10;
    localparam int IRQ_VEC0 = NEXC + (1 << TRAP_W);

    localparam logic [VEC_W-1:0] VEC_BADMEM = VEC_W'(0);
    localparam logic [VEC_W-1:0] VEC_DIVZ   = VEC_W'(1);
    localparam logic [VEC_W-1:0] VEC_PRIV   = VEC_W'(2);

    typedef enum logic [2:0] {
        S_IDLE, S_PUSH_PC, S_PUSH_PS, S_FETCH, S_JUMP, S_POP_PS, S_POP_PC
    } seq_state_e;

    typedef enum logic [1:0] { K_NONE, K_EXC, K_TRAP, K_IRQ } evt_kind_e;

    typedef struct packed {
        evt_kind_e         kind;
        logic [VEC_W-1:0]  vec;
        logic [LVL_W-1:0]  lvl;
    } evt_pick_t;

    typedef struct packed {
        logic              sup;
        logic [LVL_W-1:0]  ipl;
    } stat_t;

    function automatic logic [VEC_W-1:0] trap_vector(input logic [TRAP_W-1:0] n);
        return VEC_W'(NEXC) + VEC_W'(n);
    endfunction
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= din;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[k] <= '0;
            else     chain[k] <= chain[k-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/evt_arbiter.sv
module evt_arbiter
    import evt_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic                   bad_mem,
    input  logic                   div_zero,
    input  logic                   priv_fault,
    input  logic                   trap_req,
    input  logic [TRAP_W-1:0]      trap_num,
    input  logic [NSRC-1:0]        irq_pend,
    input  logic [NSRC*LVL_W-1:0]  irq_lvl,
    input  logic [LVL_W-1:0]       cur_ipl,
    output evt_pick_t              pick
);
    logic                 best_found;
    logic [LVL_W-1:0]     best_lvl;
    logic [VEC_W-1:0]     best_idx;

    // strict compare keeps the lowest index on ties
    always_comb begin
        best_found = 1'b0;
        best_lvl   = '0;
        best_idx   = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (irq_pend[i] && (irq_lvl[i*LVL_W +: LVL_W] > cur_ipl) &&
                (!best_found || (irq_lvl[i*LVL_W +: LVL_W] > best_lvl))) begin
                best_found = 1'b1;
                best_lvl   = irq_lvl[i*LVL_W +: LVL_W];
                best_idx   = VEC_W'(i);
            end
        end
    end

    always_comb begin
        pick = '{kind: K_NONE, vec: '0, lvl: '0};
        if (bad_mem)         pick = '{kind: K_EXC,  vec: VEC_BADMEM, lvl: '0};
        else if (div_zero)   pick = '{kind: K_EXC,  vec: VEC_DIVZ,   lvl: '0};
        else if (priv_fault) pick = '{kind: K_EXC,  vec: VEC_PRIV,   lvl: '0};
        else if (trap_req)   pick = '{kind: K_TRAP, vec: trap_vector(trap_num), lvl: '0};
        else if (best_found) pick = '{kind: K_IRQ,  vec: VEC_W'(IRQ_VEC0) + best_idx,
                                      lvl: best_lvl};
    end
endmodule

// File: rtl/evt_seq_core.sv
module evt_seq_core
    import evt_pkg::*;
#(
    parameter int              AW       = 16,
    parameter int              DW       = 16,
    parameter logic [AW-1:0]   VEC_BASE = 16'h0100,
    parameter logic [AW-1:0]   SP_INIT  = 16'h0400
) (
    input  logic              clk,
    input  logic              rst,
    input  evt_pick_t         pick,
    input  logic              ret_req,
    input  logic [AW-1:0]     core_pc,
    output logic              busy,
    output logic              pc_load,
    output logic [AW-1:0]     pc_target,
    output stat_t             status,
    output logic [AW-1:0]     sp,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [DW-1:0]     mem_wdata,
    input  logic [DW-1:0]     mem_rdata,
    input  logic              mem_ack
);
    seq_state_e        st;
    logic [AW-1:0]     save_pc;
    stat_t             save_st;
    logic [LVL_W-1:0]  next_ipl;
    logic [VEC_W-1:0]  vec_q;
    stat_t             popped;

    assign popped = stat_t'(mem_rdata[LVL_W:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= S_IDLE;
            sp        <= SP_INIT;
            status    <= '{sup: 1'b1, ipl: '0};
            save_pc   <= '0;
            save_st   <= '0;
            next_ipl  <= '0;
            vec_q     <= '0;
            pc_target <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (pick.kind != K_NONE) begin
                        save_pc  <= core_pc;
                        save_st  <= status;
                        vec_q    <= pick.vec;
                        next_ipl <= (pick.kind == K_IRQ) ? pick.lvl : status.ipl;
                        st       <= S_PUSH_PC;
                    end else if (ret_req) begin
                        st <= S_POP_PS;
                    end
                end
                S_PUSH_PC: if (mem_ack) begin
                    sp <= sp - AW'(1);
                    st <= S_PUSH_PS;
                end
                S_PUSH_PS: if (mem_ack) begin
                    sp         <= sp - AW'(1);
                    status.ipl <= next_ipl;
                    status.sup <= 1'b1;
                    st         <= S_FETCH;
                end
                S_FETCH: if (mem_ack) begin
                    pc_target <= mem_rdata[AW-1:0];
                    st        <= S_JUMP;
                end
                S_JUMP: st <= S_IDLE;
                S_POP_PS: if (mem_ack) begin
                    status <= popped;
                    sp     <= sp + AW'(1);
                    st     <= S_POP_PC;
                end
                S_POP_PC: if (mem_ack) begin
                    pc_target <= mem_rdata[AW-1:0];
                    sp        <= sp + AW'(1);
                    st        <= S_JUMP;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            S_PUSH_PC: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp - AW'(1); mem_wdata = DW'(save_pc);
            end
            S_PUSH_PS: begin
                mem_req = 1'b1; mem_we = 1'b1;
                mem_addr = sp - AW'(1); mem_wdata = DW'(save_st);
            end
            S_FETCH: begin
                mem_req = 1'b1; mem_addr = VEC_BASE + AW'(vec_q);
            end
            S_POP_PS, S_POP_PC: begin
                mem_req = 1'b1; mem_addr = sp;
            end
            default: ;
        endcase
    end

    assign busy    = (st != S_IDLE);
    assign pc_load = (st == S_JUMP);
endmodule

// File: rtl/evt_seq.sv
module evt_seq
    import evt_pkg::*;
#(
    parameter int              NSRC     = 4,
    parameter int              AW       = 16,
    parameter int              DW       = 16,
    parameter logic [AW-1:0]   VEC_BASE = 16'h0100,
    parameter logic [AW-1:0]   SP_INIT  = 16'h0400
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NSRC-1:0]        irq_req,
    input  logic [NSRC*LVL_W-1:0]  irq_lvl,
    input  logic                   trap_req,
    input  logic [TRAP_W-1:0]      trap_num,
    input  logic                   fault_mem,
    input  logic                   fault_div,
    input  logic                   priv_op,
    input  logic                   ret_req,
    input  logic [AW-1:0]          core_pc,
    output logic                   busy,
    output logic                   pc_load,
    output logic [AW-1:0]          pc_target,
    output logic                   sup_mode,
    output logic [LVL_W-1:0]       cur_ipl,
    output logic [AW-1:0]          sp_out,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [AW-1:0]          mem_addr,
    output logic [DW-1:0]          mem_wdata,
    input  logic [DW-1:0]          mem_rdata,
    input  logic                   mem_ack
);
    logic [NSRC-1:0] irq_pend;
    evt_pick_t       pick;
    stat_t           status;

    evt_sync #(.N(NSRC), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .din(irq_req), .dout(irq_pend)
    );

    evt_arbiter #(.NSRC(NSRC)) u_arb (
        .bad_mem(fault_mem), .div_zero(fault_div),
        .priv_fault(priv_op & ~status.sup),
        .trap_req(trap_req), .trap_num(trap_num),
        .irq_pend(irq_pend), .irq_lvl(irq_lvl),
        .cur_ipl(status.ipl), .pick(pick)
    );

    evt_seq_core #(.AW(AW), .DW(DW), .VEC_BASE(VEC_BASE), .SP_INIT(SP_INIT)) u_core (
        .clk(clk), .rst(rst), .pick(pick), .ret_req(ret_req), .core_pc(core_pc),
        .busy(busy), .pc_load(pc_load), .pc_target(pc_target), .status(status),
        .sp(sp_out), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    assign sup_mode = status.sup;
    assign cur_ipl  = status.ipl;
endmodule

// File: rtl/evt_seq_chk.sv
module evt_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          pc_load,
    input logic          sup_mode,
    input logic [2:0]    cur_ipl,
    input logic [AW-1:0] sp_out,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (!busy && !mem_req && !pc_load && sup_mode && cur_ipl == 3'd0));

    p_push_below_sp_r4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_addr == sp_out - AW'(1)));

    p_jump_ends_r5: assert property (@(posedge clk) disable iff (rst)
        pc_load |=> !busy);

    p_idle_keeps_state_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(cur_ipl) && $stable(sup_mode)));

    p_req_inside_busy_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req || pc_load) |-> busy);

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_sp_only_on_ack_r12: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && mem_ack) |=> $stable(sp_out));

    p_sp_single_step_r12: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |=> (sp_out == $past(sp_out) ||
                                  sp_out == $past(sp_out) + AW'(1) ||
                                  sp_out == $past(sp_out) - AW'(1)));
endmodule

bind evt_seq evt_seq_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .pc_load(pc_load), .sup_mode(sup_mode),
    .cur_ipl(cur_ipl), .sp_out(sp_out), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_ack(mem_ack)
);

// File: tb/sim_evt_seq.sv
`timescale 1ns/1ps
module sim_evt_seq;
    localparam int NSRC = 4;
    localparam int NEXC = 4;
    localparam int IRQ0 = 260;
    localparam logic [15:0] VBASE = 16'h0100;
    localparam logic [15:0] SPI   = 16'h0400;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NSRC-1:0] irq_req = '0;
    logic [NSRC*3-1:0] irq_lvl = '0;
    logic trap_req = 1'b0, fault_mem = 1'b0, fault_div = 1'b0, priv_op = 1'b0, ret_req = 1'b0;
    logic [7:0]  trap_num = '0;
    logic [15:0] core_pc = '0;
    logic busy, pc_load, sup_mode, mem_req, mem_we;
    logic [2:0]  cur_ipl;
    logic [15:0] pc_target, sp_out, mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic mem_ack = 1'b0;

    logic [15:0] mem [0:2047];
    logic        poke_en = 1'b0;
    logic [10:0] poke_a = '0;
    logic [15:0] poke_d = '0;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [15:0] esp;

    always #4 clk = ~clk;

    evt_seq #(.NSRC(NSRC), .AW(16), .DW(16), .VEC_BASE(VBASE), .SP_INIT(SPI)) u0 (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .trap_req(trap_req), .trap_num(trap_num), .fault_mem(fault_mem),
        .fault_div(fault_div), .priv_op(priv_op), .ret_req(ret_req), .core_pc(core_pc),
        .busy(busy), .pc_load(pc_load), .pc_target(pc_target), .sup_mode(sup_mode),
        .cur_ipl(cur_ipl), .sp_out(sp_out), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    // memory model: acknowledge one cycle after a request
    always @(posedge clk) begin
        if (poke_en) mem[poke_a] <= poke_d;
        if (mem_req && !mem_ack) begin
            mem_ack   <= 1'b1;
            mem_rdata <= mem[mem_addr[10:0]];
            if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
        end else begin
            mem_ack <= 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] hnd(input int v);
        return 16'h8000 + 16'(v * 7);
    endfunction

    task automatic poke(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk); poke_en = 1'b1; poke_a = a; poke_d = d;
        @(negedge clk); poke_en = 1'b0;
    endtask

    task automatic pulse(input logic p_mem, input logic p_div, input logic p_prv,
                         input logic p_trp, input logic [7:0] p_num, input logic p_ret);
        @(negedge clk);
        fault_mem = p_mem; fault_div = p_div; priv_op = p_prv;
        trap_req = p_trp; trap_num = p_num; ret_req = p_ret;
        @(negedge clk);
        fault_mem = 0; fault_div = 0; priv_op = 0; trap_req = 0; ret_req = 0;
    endtask

    task automatic expect_entry(input string tag, input int vec, input logic [15:0] pc,
                                input logic [3:0] ps, input logic [2:0] nipl);
        bit got = 0;
        for (int k = 0; k < 40 && !got; k++) begin
            @(negedge clk);
            if (pc_load) got = 1;
        end
        esp = esp - 16'd2;
        chk(got, {tag, " jump seen"}, 32'(got), 1);
        chk(pc_target == hnd(vec), {tag, " R5 handler word"}, pc_target, hnd(vec));
        chk(mem[11'(esp + 16'd1)] == pc, {tag, " R4 saved PC"}, mem[11'(esp + 16'd1)], pc);
        chk(mem[11'(esp)][3:0] == ps, {tag, " R4 saved status"}, mem[11'(esp)], ps);
        chk(sp_out == esp, {tag, " R12 SP after pushes"}, sp_out, esp);
        chk(cur_ipl == nipl, {tag, " R5 new level"}, cur_ipl, nipl);
        chk(sup_mode == 1'b1, {tag, " R6 supervisor"}, sup_mode, 1);
        @(negedge clk);
    endtask

    task automatic do_return();
        logic [3:0]  ps_top;
        logic [15:0] pc_top;
        bit got = 0;
        ps_top = mem[11'(esp)][3:0];
        pc_top = mem[11'(esp + 16'd1)];
        pulse(0, 0, 0, 0, 8'd0, 1);
        for (int k = 0; k < 40 && !got; k++) begin
            @(negedge clk);
            if (pc_load) got = 1;
        end
        esp = esp + 16'd2;
        chk(got, "R10 return jump", 32'(got), 1);
        chk(pc_target == pc_top, "R10 restored PC", pc_target, pc_top);
        chk(cur_ipl == ps_top[2:0], "R10 restored level", cur_ipl, ps_top[2:0]);
        chk(sup_mode == ps_top[3], "R10 restored mode", sup_mode, ps_top[3]);
        chk(sp_out == esp, "R12 SP after pops", sp_out, esp);
        @(negedge clk);
    endtask

    task automatic idle_check(input string tag, input int n);
        bit bad = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (busy || mem_req || pc_load) bad = 1;
        end
        chk(!bad && sp_out == esp, tag, {15'd0, bad, sp_out}, {16'd0, esp});
    endtask

    task automatic set_state(input logic m, input logic [2:0] l);
        logic [3:0] ps_now;
        ps_now  = {sup_mode, cur_ipl};
        core_pc = 16'h0ABC;
        pulse(0, 0, 0, 1, 8'd0, 0);
        expect_entry("R6 setup trap", NEXC, 16'h0ABC, ps_now, ps_now[2:0]);
        poke(11'(esp), {12'd0, m, l});
        do_return();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lv [4] = '{2, 5, 5, 3};
        for (int v = 0; v < IRQ0 + NSRC; v++) begin
            @(negedge clk); poke_en = 1'b1; poke_a = 11'(VBASE + 16'(v)); poke_d = hnd(v);
        end
        @(negedge clk); poke_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        esp = SPI;
        // R1 reset values
        chk(!busy && !mem_req && !pc_load, "R1 idle after reset", {busy, mem_req, pc_load}, 0);
        chk(sup_mode == 1'b1 && cur_ipl == 3'd0, "R1 mode and level", {sup_mode, cur_ipl}, 4'h8);
        chk(sp_out == SPI, "R1 stack pointer", sp_out, SPI);

        // R6: every trap number, alternating mode and level
        for (int n = 0; n < 256; n++) begin
            logic [7:0] nb;
            nb = 8'(n);
            set_state(nb[0], nb[3:1]);
            core_pc = 16'h2000 + 16'(n);
            pulse(0, 0, 0, 1, nb, 0);
            expect_entry("R6 trap", NEXC + n, 16'h2000 + 16'(n), {nb[0], nb[3:1]}, nb[3:1]);
            do_return();
        end

        // R2: each source, each level, each current level
        for (int s = 0; s < NSRC; s++) begin
            for (int lvl = 1; lvl < 8; lvl++) begin
                for (int c = 0; c < 8; c++) begin
                    set_state(1'b1, 3'(c));
                    irq_lvl = '0;
                    irq_lvl[s*3 +: 3] = 3'(lvl);
                    core_pc = 16'h3000 + 16'(s * 64 + lvl * 8 + c);
                    @(negedge clk); irq_req[s] = 1'b1;
                    if (lvl > c) begin
                        expect_entry("R2 taken", IRQ0 + s, core_pc, {1'b1, 3'(c)}, 3'(lvl));
                        irq_req = '0;
                        repeat (3) @(negedge clk);
                        do_return();
                    end else begin
                        idle_check("R2 masked request ignored", 8);
                        irq_req = '0;
                        repeat (3) @(negedge clk);
                    end
                end
            end
        end

        // R3: every request pattern against fixed levels, two current levels
        irq_lvl = {3'd3, 3'd5, 3'd5, 3'd2};
        for (int ci = 0; ci < 2; ci++) begin
            int c;
            c = (ci == 0) ? 0 : 3;
            for (int m = 1; m < 16; m++) begin
                int best, bl;
                best = -1; bl = 0;
                for (int i = 0; i < NSRC; i++)
                    if (m[i] && lv[i] > c && (best < 0 || lv[i] > bl)) begin
                        best = i; bl = lv[i];
                    end
                set_state(1'b1, 3'(c));
                core_pc = 16'h4000 + 16'(m);
                @(negedge clk); irq_req = 4'(m);
                if (best >= 0) begin
                    expect_entry("R3 select", IRQ0 + best, core_pc, {1'b1, 3'(c)}, 3'(bl));
                    irq_req = '0;
                    repeat (3) @(negedge clk);
                    do_return();
                end else begin
                    idle_check("R3 all masked", 8);
                    irq_req = '0;
                    repeat (3) @(negedge clk);
                end
            end
        end

        // R7 faults from user mode
        set_state(1'b0, 3'd2); core_pc = 16'h5001;
        pulse(1, 0, 0, 0, 8'd0, 0);
        expect_entry("R7 bad access", 0, 16'h5001, 4'h2, 3'd2);
        do_return();
        set_state(1'b0, 3'd2); core_pc = 16'h5002;
        pulse(0, 1, 0, 0, 8'd0, 0);
        expect_entry("R7 divide by zero", 1, 16'h5002, 4'h2, 3'd2);
        do_return();
        set_state(1'b0, 3'd2); core_pc = 16'h5003;
        pulse(1, 1, 0, 0, 8'd0, 0);
        expect_entry("R7 bad access over divide", 0, 16'h5003, 4'h2, 3'd2);
        do_return();
        // R8 privileged operation
        set_state(1'b0, 3'd5); core_pc = 16'h5004;
        pulse(0, 0, 1, 0, 8'd0, 0);
        expect_entry("R8 user privileged op", 2, 16'h5004, 4'h5, 3'd5);
        do_return();
        set_state(1'b1, 3'd5);
        pulse(0, 0, 1, 0, 8'd0, 0);
        idle_check("R8 supervisor privileged op ignored", 6);
        set_state(1'b0, 3'd1); core_pc = 16'h5005;
        pulse(0, 1, 1, 0, 8'd0, 0);
        expect_entry("R7 divide over privileged", 1, 16'h5005, 4'h1, 3'd1);
        do_return();

        // R9 fault beats trap
        set_state(1'b0, 3'd1); core_pc = 16'h6001;
        pulse(0, 1, 0, 1, 8'd7, 0);
        expect_entry("R9 fault over trap", 1, 16'h6001, 4'h1, 3'd1);
        do_return();
        // R9 trap beats a synchronized interrupt in the same cycle
        set_state(1'b1, 3'd0); core_pc = 16'h6002;
        irq_lvl = {9'd0, 3'd4};
        @(negedge clk); irq_req = 4'b0001;
        @(negedge clk);
        pulse(0, 0, 0, 1, 8'd9, 0);
        expect_entry("R9 trap over interrupt", NEXC + 9, 16'h6002, 4'h8, 3'd0);
        expect_entry("R9 interrupt after trap", IRQ0, 16'h6002, 4'h8, 3'd4);
        irq_req = '0;
        repeat (3) @(negedge clk);
        do_return();
        do_return();

        // R11 busy and dropped pulse
        set_state(1'b1, 3'd0); core_pc = 16'h7001;
        pulse(0, 0, 0, 1, 8'd5, 0);
        chk(busy == 1'b1, "R11 busy during entry", busy, 1);
        pulse(0, 0, 0, 1, 8'd9, 0);
        expect_entry("R11 first trap only", NEXC + 5, 16'h7001, 4'h8, 3'd0);
        idle_check("R11 trap during busy dropped", 8);
        do_return();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule